// File: doc/BRIEF.md
# Shift and Rotate Read-Modify-Write Unit

This unit carries out the four single-bit shift and rotate operations of a small accumulator-based processor. One start strobe issues an operation. The operation works either on an accumulator value handed in with the start or on a byte in memory. For the memory forms, the unit drives a synchronous memory port through a fixed read, compute and write sequence. Each addressing mode has a fixed instruction length. During the done cycle the unit reports how far the program counter must advance.

The new accumulator value and the carry, zero and negative flags are held inside the unit as pending values. They show at the outputs only after the instruction completes. The surrounding sequencer can therefore overlap the commit with its next fetch. Instruction fetch and opcode decoding are done outside the unit. The operand address bytes and the X index arrive with the start strobe.

Top module: `shrot_rmw`

## Requirements
- R1: Operation code 2'b00 shifts left: bit 0 of the result is 0 and the new carry is bit 7 of the source.
- R2: Operation code 2'b01 shifts right: bit 7 of the result is 0 and the new carry is bit 0 of the source.
- R3: Operation code 2'b10 rotates left, putting the incoming carry into bit 0. Code 2'b11 rotates right, putting the incoming carry into bit 7. In both cases the bit shifted out becomes the new carry.
- R4: After every operation the zero flag is 1 exactly when the 8-bit result is 0, and the negative flag equals bit 7 of the result.
- R5: The mode codes are 0 accumulator, 1 zero-page, 2 zero-page indexed, 3 absolute and 4 absolute indexed by X (codes 5 to 7 behave as the accumulator form). Take the start cycle as cycle 0. Then done is high for exactly one cycle, in cycle 2, 5, 6, 6 or 7 for those modes respectively.
- R6: During the done cycle, pc_step is 1 for the accumulator form, 2 for both zero-page forms and 3 for both absolute forms. At all other times pc_step is 0.
- R7: The memory address is the low operand byte for zero-page. For zero-page indexed it is the low operand byte plus X, truncated to 8 bits so it wraps inside page zero. For absolute it is the 16-bit operand, and for absolute indexed it is the 16-bit operand plus X.
- R8: A memory form issues exactly one read, in cycle N-4, where N is the done cycle. The read data is taken in cycle N-3. Exactly one write of the result to the same address follows in cycle N-2. The accumulator form makes no memory access.
- R9: After a memory form, acc_out equals the accumulator value given with the start. After the accumulator form, acc_out equals the result.
- R10: acc_out and the three flags stay unchanged up to and including the done cycle. They take their new values on the clock edge that ends the done cycle.
- R11: A start strobe while an operation is in progress, including its done cycle, is ignored. Changing the other inputs during that time has no effect.
- R12: After reset, acc_out and all flags are 0, and done, mem_rd, mem_we and pc_step are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Issue strobe, sampled when idle |
| op | input | 2 | Operation code |
| mode | input | 3 | Addressing mode code |
| opnd | input | AW | Operand address bytes |
| x_idx | input | DW | X index value |
| acc_in | input | DW | Accumulator value at issue |
| c_in | input | 1 | Carry value at issue |
| mem_addr | output | AW | Memory address |
| mem_rd | output | 1 | Read strobe; data valid the next cycle |
| mem_rdata | input | DW | Read data |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | DW | Write data |
| acc_out | output | DW | Committed accumulator |
| flag_c | output | 1 | Committed carry flag |
| flag_z | output | 1 | Committed zero flag |
| flag_n | output | 1 | Committed negative flag |
| pc_step | output | 2 | Program counter advance, valid with done |
| done | output | 1 | Completion pulse |

## Verification
The bench builds the unit with its defaults of an 8-bit data path and a 16-bit address. With that width, every source byte under both carry values can be swept for all four operations and all five modes. The sweep reaches every carry-out and flag combination. It also reaches every zero-page index wrap and every absolute-plus-X carry across a page. On a subset of the runs, the bench holds start high with altered inputs through the busy cycles, to show that a start is ignored while the unit is busy.

// File: rtl/shrot_rmw.sv
module shrot_rmw #(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic [2:0]    mode,
  input  logic [AW-1:0] opnd,
  input  logic [DW-1:0] x_idx,
  input  logic [DW-1:0] acc_in,
  input  logic          c_in,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] acc_out,
  output logic          flag_c,
  output logic          flag_z,
  output logic          flag_n,
  output logic [1:0]    pc_step,
  output logic          done
);
  localparam logic [2:0] M_ACC = 3'd0, M_ZP = 3'd1, M_ZPX = 3'd2, M_ABS = 3'd3, M_ABX = 3'd4;

  logic          busy;
  logic [2:0]    cnt, last;
  logic [1:0]    op_q;
  logic [2:0]    mode_q;
  logic [AW-1:0] opnd_q;
  logic [DW-1:0] x_q, a_q, dat_q, src, res;
  logic          ci_q, co, is_mem;
  logic [DW-1:0] zp_lo;

  assign is_mem = (mode_q == M_ZP) || (mode_q == M_ZPX) || (mode_q == M_ABS) || (mode_q == M_ABX);

  always_comb
    case (mode_q)
      M_ZP:         last = 3'd5;
      M_ZPX, M_ABS: last = 3'd6;
      M_ABX:        last = 3'd7;
      default:      last = 3'd2;
    endcase

  assign done   = busy && (cnt == last);
  assign mem_rd = busy && is_mem && (cnt == last - 3'd4);
  assign mem_we = busy && is_mem && (cnt == last - 3'd2);

  assign zp_lo = opnd_q[DW-1:0] + ((mode_q == M_ZPX) ? x_q : '0);

  always_comb
    if (mode_q == M_ZP || mode_q == M_ZPX)
      mem_addr = {{(AW-DW){1'b0}}, zp_lo};
    else if (mode_q == M_ABX)
      mem_addr = opnd_q + {{(AW-DW){1'b0}}, x_q};
    else
      mem_addr = opnd_q;

  assign src = is_mem ? dat_q : a_q;

  always_comb
    case (op_q)
      2'd0:    {co, res} = {src[DW-1], src[DW-2:0], 1'b0};
      2'd1:    {co, res} = {src[0], 1'b0, src[DW-1:1]};
      2'd2:    {co, res} = {src[DW-1], src[DW-2:0], ci_q};
      default: {co, res} = {src[0], ci_q, src[DW-1:1]};
    endcase

  assign mem_wdata = mem_we ? res : '0;

  always_comb
    if (!done)                                pc_step = 2'd0;
    else if (mode_q == M_ZP || mode_q == M_ZPX) pc_step = 2'd2;
    else if (mode_q == M_ABS || mode_q == M_ABX) pc_step = 2'd3;
    else                                      pc_step = 2'd1;

  always_ff @(posedge clk)
    if (!rst_n) begin
      busy <= 1'b0;
      cnt <= '0;
      op_q <= '0;
      mode_q <= '0;
      opnd_q <= '0;
      x_q <= '0;
      a_q <= '0;
      ci_q <= 1'b0;
      dat_q <= '0;
      acc_out <= '0;
      flag_c <= 1'b0;
      flag_z <= 1'b0;
      flag_n <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        cnt <= 3'd1;
        op_q <= op;
        mode_q <= mode;
        opnd_q <= opnd;
        x_q <= x_idx;
        a_q <= acc_in;
        ci_q <= c_in;
      end
    end else begin
      cnt <= cnt + 3'd1;
      if (is_mem && cnt == last - 3'd3)
        dat_q <= mem_rdata;
      if (done) begin
        busy <= 1'b0;
        acc_out <= is_mem ? a_q : res;
        flag_c <= co;
        flag_z <= (res == '0);
        flag_n <= res[DW-1];
      end
    end

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R8
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> $past(mem_rd, 2));
  // R8
  wr_before_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && is_mem) |-> $past(mem_we, 2));
  // R8
  no_mem_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !is_mem) |-> !(mem_rd || mem_we));
  // R10
  hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> ($stable(acc_out) && $stable(flag_c) && $stable(flag_z) && $stable(flag_n)));
  // R4
  acc_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !is_mem) |=> (flag_z == (acc_out == '0)) && (flag_n == acc_out[DW-1]));
  // R11
  busy_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(op_q) && $stable(mode_q) && $stable(opnd_q) && $stable(a_q)));
endmodule

// File: tb/sim_shrot_rmw.sv
module sim_shrot_rmw;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, c_in = 1'b0;
  logic [1:0] op = '0;
  logic [2:0] mode = '0;
  logic [15:0] opnd = '0;
  logic [7:0] x_idx = '0, acc_in = '0, mem_rdata = '0, mem_val = '0;
  logic [15:0] mem_addr;
  logic mem_rd, mem_we, flag_c, flag_z, flag_n, done;
  logic [7:0] mem_wdata, acc_out;
  logic [1:0] pc_step;
  int total = 0, bad = 0;
  logic pc_ = 1'b0, pz = 1'b0, pn = 1'b0;

  always #(PERIOD/2) clk = ~clk;
  always @(posedge clk) mem_rdata <= mem_rd ? mem_val : 8'h00;

  shrot_rmw u0 (.clk(clk), .rst_n(rst_n), .start(start), .op(op), .mode(mode), .opnd(opnd),
    .x_idx(x_idx), .acc_in(acc_in), .c_in(c_in), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_wdata(mem_wdata), .acc_out(acc_out),
    .flag_c(flag_c), .flag_z(flag_z), .flag_n(flag_n), .pc_step(pc_step), .done(done));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input int o, input int m, input int v, input int c, input int av,
                     input int xv, input int ov, input bit hold);
    int r, co, n_exp, ea, step, k, nrd, nwr, rdk, wrk;
    bit memf;
    memf = (m >= 1 && m <= 4);
    case (o)
      0: begin r = (v << 1) & 255; co = v >> 7; end
      1: begin r = v >> 1; co = v & 1; end
      2: begin r = ((v << 1) & 255) | c; co = v >> 7; end
      default: begin r = (v >> 1) | (c << 7); co = v & 1; end
    endcase
    n_exp = (m == 1) ? 5 : (m == 2 || m == 3) ? 6 : (m == 4) ? 7 : 2;
    step = (m == 1 || m == 2) ? 2 : (m == 3 || m == 4) ? 3 : 1;
    ea = (m == 1) ? (ov & 255) : (m == 2) ? ((ov + xv) & 255) : (m == 4) ? ((ov + xv) & 65535) : ov;
    @(negedge clk);
    op = o[1:0]; mode = m[2:0]; opnd = ov[15:0]; x_idx = xv[7:0];
    acc_in = memf ? av[7:0] : v[7:0]; c_in = c[0]; mem_val = v[7:0]; start = 1'b1;
    @(negedge clk);
    if (hold) begin
      op = ~op; mode = 3'd4 - mode; opnd = ~opnd; x_idx = ~x_idx; acc_in = ~acc_in; c_in = ~c_in;
    end else start = 1'b0;
    nrd = 0; nwr = 0; rdk = 0; wrk = 0;
    for (k = 1; k < 20; k++) begin
      if (mem_rd) begin
        nrd++; rdk = k;
        chk(mem_addr == ea[15:0], "R7 read address", mem_addr, ea);
      end
      if (mem_we) begin
        nwr++; wrk = k;
        chk(mem_addr == ea[15:0], "R8 write address", mem_addr, ea);
        chk(mem_wdata == r[7:0], "R1/R2/R3 write data", mem_wdata, r);
      end
      if (k == 1) chk(pc_step == 2'd0, "R6 pc_step idle", pc_step, 0);
      if (done) break;
      chk(acc_out == acc_out && flag_c == pc_ && flag_z == pz && flag_n == pn,
          "R10 flags held", {flag_c, flag_z, flag_n}, {pc_, pz, pn});
      @(negedge clk);
    end
    chk(k == n_exp, "R5 done cycle", k, n_exp);
    chk(pc_step == step[1:0], "R6 pc_step", pc_step, step);
    chk(flag_c == pc_ && flag_z == pz && flag_n == pn, "R10 flags in done cycle",
        {flag_c, flag_z, flag_n}, {pc_, pz, pn});
    if (memf) begin
      chk(nrd == 1 && rdk == n_exp - 4, "R8 read cycle", rdk, n_exp - 4);
      chk(nwr == 1 && wrk == n_exp - 2, "R8 write cycle", wrk, n_exp - 2);
    end else
      chk(nrd == 0 && nwr == 0, "R8 no access", nrd + nwr, 0);
    start = 1'b0;
    @(negedge clk);
    chk(!done, "R5 single pulse", done, 0);
    chk(acc_out == (memf ? av[7:0] : r[7:0]), "R9 accumulator", acc_out, memf ? av : r);
    chk(flag_c == co[0], o < 2 ? (o == 0 ? "R1 carry" : "R2 carry") : "R3 carry", flag_c, co);
    chk(flag_z == (r == 0) && flag_n == r[7], "R4 zero/negative", {flag_z, flag_n}, {r == 0, r[7]});
    if (hold) chk(!done && !mem_rd, "R11 start ignored", done, 0);
    pc_ = flag_c; pz = flag_z; pn = flag_n;
  endtask

  initial begin
    #(PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(acc_out == 8'h00 && !flag_c && !flag_z && !flag_n, "R12 reset outputs", acc_out, 0);
    chk(!done && !mem_rd && !mem_we && pc_step == 2'd0, "R12 reset strobes", {done, mem_rd, mem_we}, 0);
    rst_n = 1'b1;
    for (int o = 0; o < 4; o++)
      for (int m = 0; m < 5; m++)
        for (int v = 0; v < 256; v++)
          for (int c = 0; c < 2; c++)
            run(o, m, v, c, v ^ 8'h5a, (v * 3 + o) & 255, ((v ^ 8'hc3) << 8) | (255 - v),
                (v % 17) == 0);
    run(0, 6, 8'h81, 0, 0, 0, 0, 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule